// File: doc/BRIEF.md
# Multi-Counter Range Comparison Output Unit

This block watches the present values of several counters and compares each one, on every clock, against a private table of programmable ranges. Every table entry holds an inclusive lower limit, an inclusive upper limit and a 12-bit output pattern. While a counter's value sits inside an entry's range, that entry's pattern goes into the counter's result word. When several ranges hold the value at once, their patterns are merged by OR. When no range holds it, the result word is zero.

In each result word, bits 7..0 are flags for local use. Bits 11..8 feed four shared external pins. Each pin is the OR of the matching bit across the result words of all counters. A per-counter enable forces that counter's word to zero, which also removes it from the pins. Host logic loads the tables through a write port that uses valid/ready. That port never applies back-pressure: `wr_ready` is held high, and every cycle with `wr_valid` high performs one write. The present-value inputs, enables, result words and pins are plain level signals.

Top module: `range_cmp_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), every result word and every external pin is zero, and every table field is zero.
- R2: Entry e of counter c matches when lower <= PV <= upper, with both limits and PV treated as 24-bit unsigned numbers. Results are registered: a PV change applied before clock edge N is reflected after edge N.
- R3: An entry whose lower limit is greater than its upper limit never contributes to the result.
- R4: The result word is the bitwise OR of the patterns of all matching entries. It is all zeros when no entry matches.
- R5: Counter c's 12-bit result word occupies `res[c*12 +: 12]`. Bits 7..0 carry pattern bits 7..0 (internal flags) and bits 11..8 carry pattern bits 11..8.
- R6: `ext_out[k]` (k = 0..3) is the OR of bit 8+k of all four registered result words.
- R7: When `cnt_en[c]` is 0, counter c's result word is zero after the next edge, and the counter adds nothing to `ext_out`.
- R8: A write happens on an edge where `wr_valid` is high. `wr_ready` is always 1. `wr_fld` selects the field: 0 = lower limit (`wr_data[23:0]`), 1 = upper limit, 2 = pattern (`wr_data[11:0]`). Value 3 changes nothing. The new entry affects the results from the edge after the write edge.
- R9: A write changes only the entry addressed by `wr_cnt` and `wr_ent`. The tables of the other counters and the other entries are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Table write request |
| wr_ready | output | 1 | Write accepted; always 1 |
| wr_cnt | input | 2 | Counter index of the write |
| wr_ent | input | 4 | Entry index of the write |
| wr_fld | input | 2 | Field select: 0 lower, 1 upper, 2 pattern, 3 none |
| wr_data | input | 24 | Write value |
| cnt_en | input | 4 | Per-counter enable |
| pv | input | 96 | Present values; counter c at bits [c*24 +: 24] |
| res | output | 48 | Result words; counter c at bits [c*12 +: 12] |
| ext_out | output | 4 | Shared external outputs |

## Verification
The write-port assertions assume that `wr_cnt`, `wr_ent`, `wr_fld` and `wr_data` are known whenever `wr_valid` is high. The output assertions assume that `cnt_en` is driven to a known level on every clock. The bench changes inputs only on the falling clock edge and drives every one of them to a defined value from reset onward. Its random limits are drawn from a narrow value band, so ranges overlap, empty ranges with lower above upper occur, and PV samples from the same band hit, miss and land exactly on the limits.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  typedef enum logic [1:0] {
    FLD_LO   = 2'd0,
    FLD_HI   = 2'd1,
    FLD_PAT  = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;
endpackage

// File: rtl/rcu_entry_table.sv
module rcu_entry_table
  import rcu_pkg::*;
#(
  parameter int NENT = 16,
  parameter int PVW  = 24,
  parameter int PATW = 12,
  localparam int EIW = $clog2(NENT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [EIW-1:0]             wr_ent,
  input  logic [1:0]                 wr_fld,
  input  logic [PVW-1:0]             wr_data,
  output logic [NENT-1:0][PVW-1:0]   lo_o,
  output logic [NENT-1:0][PVW-1:0]   hi_o,
  output logic [NENT-1:0][PATW-1:0]  pat_o
);
  fld_e fld;
  assign fld = fld_e'(wr_fld);

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic sel;
    assign sel = we && (wr_ent == EIW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_o[e]  <= '0;
        hi_o[e]  <= '0;
        pat_o[e] <= '0;
      end else if (sel) begin
        case (fld)
          FLD_LO:  lo_o[e]  <= wr_data;
          FLD_HI:  hi_o[e]  <= wr_data;
          FLD_PAT: pat_o[e] <= wr_data[PATW-1:0];
          default: ;
        endcase
      end
    end
  end

  // Stored lower limit follows a lower-limit write
  p_wr_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_fld == FLD_LO) |=> lo_o[$past(wr_ent)] == $past(wr_data));
  // Field value 3 leaves the addressed pattern intact
  p_fld_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_fld == FLD_NONE) |=> $stable(pat_o));
  // No write request keeps all fields stable
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(lo_o) && $stable(hi_o) && $stable(pat_o)));
endmodule

// File: rtl/rcu_range_match.sv
module rcu_range_match #(
  parameter int NENT = 16,
  parameter int PVW  = 24,
  parameter int PATW = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PVW-1:0]             pv,
  input  logic [NENT-1:0][PVW-1:0]   lo,
  input  logic [NENT-1:0][PVW-1:0]   hi,
  input  logic [NENT-1:0][PATW-1:0]  pat,
  output logic [PATW-1:0]            word
);
  logic [NENT-1:0] hit;

  for (genvar e = 0; e < NENT; e++) begin : g_cmp
    assign hit[e] = (pv >= lo[e]) && (pv <= hi[e]);
  end

  always_comb begin
    word = '0;
    for (int e = 0; e < NENT; e++) begin
      if (hit[e]) word = word | pat[e];
    end
  end

  // No hit means an empty word
  p_nohit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (word == '0));
  // An inverted range never registers a hit
  for (genvar e = 0; e < NENT; e++) begin : g_chk
    p_inverted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo[e] > hi[e]) |-> !hit[e]);
  end
endmodule

// File: rtl/range_cmp_unit.sv
module range_cmp_unit #(
  parameter int NCNT = 4,
  parameter int NENT = 16,
  parameter int PVW  = 24,
  parameter int PATW = 12,
  parameter int NINT = 8,
  localparam int NEXT = PATW - NINT,
  localparam int CIW  = $clog2(NCNT),
  localparam int EIW  = $clog2(NENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [CIW-1:0]         wr_cnt,
  input  logic [EIW-1:0]         wr_ent,
  input  logic [1:0]             wr_fld,
  input  logic [PVW-1:0]         wr_data,
  input  logic [NCNT-1:0]        cnt_en,
  input  logic [NCNT*PVW-1:0]    pv,
  output logic [NCNT*PATW-1:0]   res,
  output logic [NEXT-1:0]        ext_out
);
  logic [NCNT-1:0][PATW-1:0] word_c;
  logic [NCNT-1:0][PATW-1:0] word_m;
  logic [NCNT-1:0][PATW-1:0] res_q;
  logic [NEXT-1:0]           ext_d;
  logic [NEXT-1:0]           ext_q;

  assign wr_ready = 1'b1;

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    logic [NENT-1:0][PVW-1:0]  lo_t;
    logic [NENT-1:0][PVW-1:0]  hi_t;
    logic [NENT-1:0][PATW-1:0] pat_t;
    logic                      we_c;

    assign we_c = wr_valid && wr_ready && (wr_cnt == CIW'(c));

    rcu_entry_table #(.NENT(NENT), .PVW(PVW), .PATW(PATW)) u_tab (
      .clk(clk), .rst_n(rst_n), .we(we_c), .wr_ent(wr_ent),
      .wr_fld(wr_fld), .wr_data(wr_data),
      .lo_o(lo_t), .hi_o(hi_t), .pat_o(pat_t)
    );

    rcu_range_match #(.NENT(NENT), .PVW(PVW), .PATW(PATW)) u_match (
      .clk(clk), .rst_n(rst_n), .pv(pv[c*PVW +: PVW]),
      .lo(lo_t), .hi(hi_t), .pat(pat_t), .word(word_c[c])
    );

    assign word_m[c] = cnt_en[c] ? word_c[c] : '0;
    assign res[c*PATW +: PATW] = res_q[c];

    // Disabled counter shows an empty word one edge later
    p_dis_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en[c] |=> (res[c*PATW +: PATW] == '0));
  end

  always_comb begin
    ext_d = '0;
    for (int c = 0; c < NCNT; c++) begin
      ext_d = ext_d | word_m[c][PATW-1:NINT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ext_q <= '0;
    end else begin
      res_q <= word_m;
      ext_q <= ext_d;
    end
  end

  assign ext_out = ext_q;

  // Each pin equals the OR of its bit over all result words
  for (genvar k = 0; k < NEXT; k++) begin : g_ext_chk
    logic any_k;
    always_comb begin
      any_k = 1'b0;
      for (int c = 0; c < NCNT; c++) any_k = any_k | res[c*PATW + NINT + k];
    end
    p_ext_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_out[k] == any_k);
  end
  // Outputs settle to zero in reset
  p_rst_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (res == '0 && ext_out == '0));
endmodule

// File: tb/sim_range_cmp_unit.sv
module sim_range_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [1:0]  wr_cnt;
  logic [3:0]  wr_ent;
  logic [1:0]  wr_fld;
  logic [23:0] wr_data;
  logic [3:0]  cnt_en;
  logic [95:0] pv;
  logic [47:0] res;
  logic [3:0]  ext_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [23:0] m_lo  [4][16];
  logic [23:0] m_hi  [4][16];
  logic [11:0] m_pat [4][16];

  range_cmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_cnt(wr_cnt), .wr_ent(wr_ent), .wr_fld(wr_fld), .wr_data(wr_data),
    .cnt_en(cnt_en), .pv(pv), .res(res), .ext_out(ext_out)
  );

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [11:0] exp_word(int c);
    logic [11:0] w = '0;
    logic [23:0] v = pv[c*24 +: 24];
    for (int e = 0; e < 16; e++)
      if (m_lo[c][e] <= v && v <= m_hi[c][e]) w |= m_pat[c][e];
    return cnt_en[c] ? w : 12'h0;
  endfunction

  function automatic logic [3:0] exp_ext();
    logic [3:0] x = '0;
    for (int c = 0; c < 4; c++) x |= exp_word(c)[11:8];
    return x;
  endfunction

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 4; c++) chk(tag, {36'h0, res[c*12 +: 12]}, {36'h0, exp_word(c)});
    chk({tag, " R6 ext"}, {44'h0, ext_out}, {44'h0, exp_ext()});
  endtask

  task automatic wr(int c, int e, int f, logic [23:0] d);
    wr_valid = 1'b1; wr_cnt = 2'(c); wr_ent = 4'(e); wr_fld = 2'(f); wr_data = d;
    step(1);
    wr_valid = 1'b0;
    case (f)
      0: m_lo[c][e] = d;
      1: m_hi[c][e] = d;
      2: m_pat[c][e] = d[11:0];
      default: ;
    endcase
  endtask

  task automatic set_pv(int c, logic [23:0] v);
    pv[c*24 +: 24] = v;
  endtask

  initial begin
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 16; e++) begin
        m_lo[c][e] = '0; m_hi[c][e] = '0; m_pat[c][e] = '0;
      end
    rst_n = 1'b0; wr_valid = 0; wr_cnt = 0; wr_ent = 0; wr_fld = 0; wr_data = 0;
    cnt_en = 4'hF; pv = {4{24'h000123}};
    step(3);
    chk("R1 reset res", res, 48'h0);
    chk("R1 reset ext", {44'h0, ext_out}, 48'h0);
    chk("R8 ready", {47'h0, wr_ready}, 48'h1);
    rst_n = 1'b1;
    step(2);
    check_all("R1 zero table");

    // R2 inclusive edges, one-cycle latency
    wr(0, 3, 0, 24'd100); wr(0, 3, 1, 24'd200); wr(0, 3, 2, 24'hA5C);
    set_pv(0, 24'd99);  step(1); check_all("R2 below");
    set_pv(0, 24'd100); step(1); check_all("R2 at lower");
    chk("R5 word c0", {36'h0, res[11:0]}, 48'hA5C);
    set_pv(0, 24'd200); step(1); check_all("R2 at upper");
    set_pv(0, 24'd201); step(1); check_all("R2 above");

    // R2 write latency: write becomes visible one edge after the write edge
    set_pv(0, 24'd150);
    wr(0, 3, 2, 24'h0F0);
    chk("R8 pre-latency", {36'h0, res[11:0]}, 48'hA5C);
    step(1); chk("R8 post-latency", {36'h0, res[11:0]}, 48'h0F0);

    // R3 inverted range
    wr(1, 0, 0, 24'd500); wr(1, 0, 1, 24'd400); wr(1, 0, 2, 24'hFFF);
    set_pv(1, 24'd450); step(1); check_all("R3 inverted");
    set_pv(1, 24'd400); step(1); check_all("R3 inverted edge");

    // R4 overlap OR and full-scale limits
    wr(2, 0, 0, 24'd10); wr(2, 0, 1, 24'hFFFFFF); wr(2, 0, 2, 24'h101);
    wr(2, 15, 0, 24'd20); wr(2, 15, 1, 24'd30); wr(2, 15, 2, 24'h810);
    set_pv(2, 24'd25); step(1); check_all("R4 overlap");
    chk("R4 overlap word", {36'h0, res[35:24]}, 48'h911);
    set_pv(2, 24'hFFFFFF); step(1); check_all("R4 full scale");
    set_pv(2, 24'd5); step(1); check_all("R4 none");

    // R8 field 3 ignored, R9 other counters untouched
    set_pv(2, 24'd25);
    wr(2, 15, 3, 24'h000000); wr(2, 0, 3, 24'h000000);
    step(1); check_all("R8 field none");
    chk("R9 c1 untouched", {36'h0, res[23:12]}, 48'h0);

    // R7 enable and R6 sharing
    wr(3, 7, 0, 24'd0); wr(3, 7, 1, 24'd50); wr(3, 7, 2, 24'h400);
    set_pv(3, 24'd50); step(1); check_all("R6 shared");
    chk("R6 pin2", {44'h0, ext_out}, {44'h0, 4'h4 | 4'h9});
    cnt_en = 4'b0111; step(1); check_all("R7 disabled");
    chk("R7 c3 zero", {36'h0, res[47:36]}, 48'h0);
    cnt_en = 4'hF; step(1); check_all("R7 re-enabled");

    // Random tables and values
    for (int it = 0; it < 300; it++) begin
      int c = $urandom(1234 + it) % 4;
      c = $urandom % 4;
      wr(c, $urandom % 16, $urandom % 4, 24'h001000 + 24'($urandom % 256));
      if ($urandom % 3 == 0) wr(c, $urandom % 16, 2, 24'($urandom));
      for (int k = 0; k < 4; k++) set_pv(k, 24'h001000 + 24'($urandom % 256));
      cnt_en = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      step(1);
      check_all("R9 random R5");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule